// File: doc/BRIEF.md
# Cascadable DDR Parallel-to-Serial Converter

This block turns a parallel word into a double-data-rate serial bit stream. Every fast clock cycle emits one bit pair, with a rising-slot bit and a falling-slot bit. It is built from two identical serializer units. The lead unit holds word bits 0 to 7 and drives the serial output. The tail unit holds the upper word bits and passes them to the lead unit through two dedicated shift lines. The tail unit has no serial output path of its own, so the pair always produces exactly one stream.

The ratio is chosen at run time from 4:1, 8:1, 10:1 and 14:1. At 4:1 and 8:1 the lead unit works alone. At 10:1 and 14:1 the tail unit is chained in. The chained ratios need double-data-rate operation. In single-data-rate mode one bit leaves per cycle and both slots carry that same bit. If a chained ratio is chosen together with single-data-rate mode, the block raises a configuration error and stays silent.

A one-cycle load strobe captures the whole word into both units at once. When the strobe repeats every ratio/2 fast cycles (every ratio cycles in single-data-rate mode), consecutive words form a stream with no gaps.

Top module: `ddr_ser_pair`

## Requirements
- R1: After a synchronous active-low reset, and until the first accepted load strobe, both output slots are 0. A reset in the middle of a word clears all shift state.
- R2: In DDR mode a word captured at a clock edge shows bits 0 and 1 in the next cycle. Bits then leave in ascending order, two per cycle, with the even-indexed bit on `q_rise_o` and the odd-indexed bit on `q_fall_o`.
- R3: ratio_sel 00 selects 4:1 and 01 selects 8:1. The lead unit works alone with word bits 0..7 from `word_i[7:0]`, and word bits at or above the ratio are ignored.
- R4: ratio_sel 10 selects 10:1. Word bits 8 and 9 come from `word_i[9:8]` through the tail unit's third and fourth data inputs, and they follow bit 7 with no gap. The tail unit's two lowest data inputs are unused.
- R5: ratio_sel 11 selects 14:1. Word bits 8..13 come from `word_i[13:8]` through the tail unit's third to eighth data inputs, in ascending order.
- R6: Loads repeated every ratio/2 cycles (DDR) or every ratio cycles (SDR) give a gapless stream. `word_i` is sampled only when `load_i` is high.
- R7: With `ddr_i`=0 and ratio 4:1 or 8:1, one bit leaves per cycle, bit 0 first, and both slots carry the same bit.
- R8: With `ddr_i`=0 and ratio 10:1 or 14:1, `cfg_err_o` is 1, loads are ignored and both slots stay 0. With `ddr_i`=1, `cfg_err_o` is 0.
- R9: At 4:1 and 8:1 the tail unit feeds nothing into the lead unit. After the last word of a stream, both slots return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | One-cycle parallel load strobe |
| ddr_i | input | 1 | 1 = two bits per cycle, 0 = one bit per cycle |
| ratio_sel_i | input | 2 | 00 = 4:1, 01 = 8:1, 10 = 10:1, 11 = 14:1 |
| word_i | input | 14 | Parallel word, bit 0 sent first |
| q_rise_o | output | 1 | Bit for the rising-edge slot |
| q_fall_o | output | 1 | Bit for the falling-edge slot |
| cfg_err_o | output | 1 | Chained ratio requested in single-data-rate mode |

## Verification
Random words are streamed back to back at every ratio in DDR mode and at 4:1 and 8:1 in SDR mode. Each emitted pair is compared with a reference ordering of the word's bits. Upper word bits above the ratio are always set to random values, and `word_i` is changed while the strobe is low. A wrong mask or a stray capture therefore shows up as an extra bit after the last word drains. The 10:1 and 14:1 runs show whether the tail unit's bits arrive right after bit 7 and in the right order. The SDR runs tell a shift of one position apart from a shift of two. Separate cases pulse loads under an illegal configuration and assert reset mid-word.

// File: rtl/ser_pkg.sv
// Shared constants and types for the cascadable serializer.
// Assumes a fixed two-unit chain: one lead unit and one tail unit.
package ser_pkg;
    localparam int UNIT_W     = 8;                              // data inputs per unit
    localparam int STEP_W     = 2;                              // bits per cycle in DDR
    localparam int TAIL_SKIP  = 2;                              // tail unit's unused low inputs
    localparam int WORD_W     = 2 * UNIT_W - TAIL_SKIP;         // widest word
    localparam int RATIO_LOW  = 4;
    localparam int RATIO_MID  = 8;
    localparam int RATIO_WIDE = 10;
    localparam int RATIO_MAX  = 14;

    typedef enum logic [1:0] {
        RSEL_4  = 2'b00,
        RSEL_8  = 2'b01,
        RSEL_10 = 2'b10,
        RSEL_14 = 2'b11
    } ratio_sel_e;

    typedef enum logic {
        ROLE_LEAD = 1'b0,
        ROLE_TAIL = 1'b1
    } unit_role_e;
endpackage

// File: rtl/ser_cfg_decode.sv
// Configuration decoder: turns the ratio code and the rate mode into a
// chain enable, an error flag and a mask of the word bits that are valid.
// Assumes the ratio code is held stable while a word is in flight.
module ser_cfg_decode
    import ser_pkg::*;
#(
    parameter int WORD_BITS = WORD_W
) (
    input  logic [1:0]           ratio_sel_i,
    input  logic                 ddr_i,
    output logic                 chain_en_o,
    output logic                 cfg_err_o,
    output logic [WORD_BITS-1:0] word_mask_o
);
    logic wide;
    int   nbits;

    // Picks the number of word bits for each ratio code.
    always_comb begin
        unique case (ratio_sel_e'(ratio_sel_i))
            RSEL_4:  nbits = RATIO_LOW;
            RSEL_8:  nbits = RATIO_MID;
            RSEL_10: nbits = RATIO_WIDE;
            default: nbits = RATIO_MAX;
        endcase
    end

    // Builds the valid-bit mask from the bit count.
    always_comb begin
        for (int i = 0; i < WORD_BITS; i++) begin
            word_mask_o[i] = (i < nbits);
        end
    end

    // Chaining needs both a wide ratio and double data rate.
    assign wide       = (ratio_sel_i == RSEL_10) || (ratio_sel_i == RSEL_14);
    assign chain_en_o = wide && ddr_i;
    assign cfg_err_o  = wide && !ddr_i;
endmodule

// File: rtl/ser_lane_unit.sv
// One serializer unit with UNIT_BITS parallel inputs and a shift register.
// A lead unit loads all of its inputs. A tail unit drops its TAIL_SKIP
// lowest inputs. Each cycle the register moves down two places (DDR) or one
// place (SDR). In DDR the top is refilled from shift_in_i.
// shift_out_o always shows the two lowest remaining bits.
// Assumes load_i has priority over shifting.
module ser_lane_unit
    import ser_pkg::*;
#(
    parameter int         UNIT_BITS = UNIT_W,
    parameter int         STEP      = STEP_W,
    parameter int         SKIP      = TAIL_SKIP,
    parameter unit_role_e ROLE      = ROLE_LEAD
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic                 ddr_i,
    input  logic [UNIT_BITS-1:0] d_i,
    input  logic [STEP-1:0]      shift_in_i,
    output logic [STEP-1:0]      shift_out_o
);
    logic [UNIT_BITS-1:0] sr_q;
    logic [UNIT_BITS-1:0] load_val;

    // Role selects which data inputs take part in the word.
    generate
        if (ROLE == ROLE_TAIL) begin : g_tail
            assign load_val = d_i >> SKIP;
        end else begin : g_lead
            assign load_val = d_i;
        end
    endgenerate

    // Shift register: load, or move two places (DDR) or one place (SDR).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load_i) begin
            sr_q <= load_val;
        end else if (ddr_i) begin
            sr_q <= {shift_in_i, sr_q[UNIT_BITS-1:STEP]};
        end else begin
            sr_q <= {1'b0, sr_q[UNIT_BITS-1:1]};
        end
    end

    assign shift_out_o = sr_q[STEP-1:0];
endmodule

// File: rtl/ddr_ser_pair.sv
// Top wrapper: one lead unit and one tail unit, joined by two shift lines.
// The lead unit's two lowest bits form the output slot pair. The tail unit
// has no output path of its own. Unused word bits are masked before the
// load. A chained ratio in SDR mode blocks loads and silences the output.
// Assumes load_i comes once per word period, aligned to clk.
module ddr_ser_pair
    import ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              ddr_i,
    input  logic [1:0]        ratio_sel_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              q_rise_o,
    output logic              q_fall_o,
    output logic              cfg_err_o
);
    localparam int HI_W = WORD_W - UNIT_W;

    logic              chain_en;
    logic [WORD_W-1:0] word_mask;
    logic [WORD_W-1:0] word_m;
    logic              lead_load;
    logic              tail_load;
    logic [UNIT_W-1:0] tail_d;
    logic [STEP_W-1:0] tail_out;
    logic [STEP_W-1:0] master_fill;
    logic [STEP_W-1:0] lead_out;

    ser_cfg_decode #(.WORD_BITS(WORD_W)) u_cfg (
        .ratio_sel_i (ratio_sel_i),
        .ddr_i       (ddr_i),
        .chain_en_o  (chain_en),
        .cfg_err_o   (cfg_err_o),
        .word_mask_o (word_mask)
    );

    // Masks the word and routes loads to the units that take part.
    assign word_m      = word_i & word_mask;
    assign lead_load   = load_i && !cfg_err_o;
    assign tail_load   = load_i && chain_en;
    assign tail_d      = {word_m[WORD_W-1:UNIT_W], {(UNIT_W - HI_W){1'b0}}};
    assign master_fill = chain_en ? tail_out : '0;

    ser_lane_unit #(.ROLE(ROLE_TAIL)) u_tail (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (tail_load),
        .ddr_i       (ddr_i),
        .d_i         (tail_d),
        .shift_in_i  ({STEP_W{1'b0}}),
        .shift_out_o (tail_out)
    );

    ser_lane_unit #(.ROLE(ROLE_LEAD)) u_lead (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (lead_load),
        .ddr_i       (ddr_i),
        .d_i         (word_m[UNIT_W-1:0]),
        .shift_in_i  (master_fill),
        .shift_out_o (lead_out)
    );

    // Output slots: DDR uses both low bits, SDR repeats bit 0 in both.
    assign q_rise_o = !cfg_err_o && lead_out[0];
    assign q_fall_o = !cfg_err_o && (ddr_i ? lead_out[1] : lead_out[0]);
endmodule

// File: rtl/ddr_ser_pair_chk.sv
// Checker for ddr_ser_pair, attached with bind. It checks output silence,
// slot ordering, the chain feed and the error gating over time.
module ddr_ser_pair_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        load_i,
    input logic        ddr_i,
    input logic [1:0]  ratio_sel_i,
    input logic [13:0] word_i,
    input logic        q_rise_o,
    input logic        q_fall_o,
    input logic        cfg_err_o,
    input logic [1:0]  master_fill
);
    logic seen_load;

    // Tracks whether any load was accepted since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                     seen_load <= 1'b0;
        else if (load_i && !cfg_err_o)  seen_load <= 1'b1;
    end

    a_r1_quiet_until_load: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_load |-> (!q_rise_o && !q_fall_o));

    a_r2_first_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && ddr_i && !cfg_err_o) |=>
        (cfg_err_o || (q_rise_o == $past(word_i[0]) &&
                       (!ddr_i || q_fall_o == $past(word_i[1])))));

    a_r4_tail_feed: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && ddr_i && ratio_sel_i[1]) |=>
        (!ddr_i || !ratio_sel_i[1] || master_fill == $past(word_i[9:8])));

    a_r7_sdr_slots_equal: assert property (@(posedge clk) disable iff (!rst_n)
        !ddr_i |-> (q_rise_o == q_fall_o));

    a_r8_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (!q_rise_o && !q_fall_o));

    a_r9_no_feed_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (!ddr_i || !ratio_sel_i[1]) |-> (master_fill == 2'b00));
endmodule

bind ddr_ser_pair ddr_ser_pair_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .ddr_i       (ddr_i),
    .ratio_sel_i (ratio_sel_i),
    .word_i      (word_i),
    .q_rise_o    (q_rise_o),
    .q_fall_o    (q_fall_o),
    .cfg_err_o   (cfg_err_o),
    .master_fill (master_fill)
);

// File: tb/ddr_ser_pair_tb.sv
// Directed bench: one task per scenario, each comparing the output slots
// with a reference bit ordering computed from the requirements.
module ddr_ser_pair_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic        ddr = 1'b1;
    logic [1:0]  rsel = 2'b00;
    logic [13:0] word = '0;
    logic        q_rise, q_fall, cfg_err;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    ddr_ser_pair u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .ddr_i       (ddr),
        .ratio_sel_i (rsel),
        .word_i      (word),
        .q_rise_o    (q_rise),
        .q_fall_o    (q_fall),
        .cfg_err_o   (cfg_err)
    );

    task automatic check3(input logic [2:0] act, input logic [2:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {err,fall,rise} actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ratio_of(input logic [1:0] s);
        case (s)
            2'b00:   return 4;
            2'b01:   return 8;
            2'b10:   return 10;
            default: return 14;
        endcase
    endfunction

    // R1: reset state and a reset in the middle of a word.
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; load = 1'b0; ddr = 1'b1; rsel = 2'b01;
        @(negedge clk);
        @(negedge clk);
        check3({cfg_err, q_fall, q_rise}, 3'b000, "R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check3({cfg_err, q_fall, q_rise}, 3'b000, "R1 idle after reset");
        word = 14'h3FFF; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        check3({cfg_err, q_fall, q_rise}, 3'b011, "R1 loaded ones");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check3({cfg_err, q_fall, q_rise}, 3'b000, "R1 mid-word reset clears");
        end
    endtask

    // R2..R7, R9: back-to-back random words, then a drain to zero.
    task automatic t_stream(input logic [1:0] s, input logic dm, input int nwords, input string req);
        int          r, steps;
        logic [13:0] cur, nxt;
        logic        er, ef;
        r = ratio_of(s);
        steps = dm ? r / 2 : r;
        @(negedge clk);
        rsel = s; ddr = dm; load = 1'b0;
        @(negedge clk);
        cur = 14'($urandom);
        nxt = cur;
        word = cur; load = 1'b1;
        for (int w = 0; w < nwords; w++) begin
            for (int k = 0; k < steps; k++) begin
                @(negedge clk);
                er = dm ? cur[2*k]     : cur[k];
                ef = dm ? cur[2*k + 1] : cur[k];
                check3({cfg_err, q_fall, q_rise}, {1'b0, ef, er}, req);
                if (k == steps - 1 && w < nwords - 1) begin
                    nxt = 14'($urandom);
                    word = nxt; load = 1'b1;
                end else begin
                    word = 14'($urandom); load = 1'b0;
                end
            end
            cur = nxt;
        end
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check3({cfg_err, q_fall, q_rise}, 3'b000, "R9 drains to zero, upper bits ignored (R3)");
        end
    endtask

    // R8: chained ratio in SDR mode flags an error and ignores loads.
    task automatic t_cfg_err(input logic [1:0] s);
        @(negedge clk);
        ddr = 1'b0; rsel = s; load = 1'b0;
        @(negedge clk);
        check3({cfg_err, q_fall, q_rise}, 3'b100, "R8 error flag");
        word = 14'h3FFF; load = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check3({cfg_err, q_fall, q_rise}, 3'b100, "R8 loads ignored");
        end
        load = 1'b0; ddr = 1'b1;
        @(negedge clk);
        check3({cfg_err, q_fall, q_rise}, 3'b000, "R8 DDR clears error, no stored word");
    endtask

    initial begin
        t_reset();
        t_stream(2'b00, 1'b1, 6, "R3 DDR 4:1 order (R2, R6)");
        t_stream(2'b01, 1'b1, 6, "R3 DDR 8:1 order (R2, R6)");
        t_stream(2'b10, 1'b1, 6, "R4 DDR 10:1 chained (R6)");
        t_stream(2'b11, 1'b1, 6, "R5 DDR 14:1 chained (R6)");
        t_stream(2'b00, 1'b0, 4, "R7 SDR 4:1");
        t_stream(2'b01, 1'b0, 4, "R7 SDR 8:1");
        t_cfg_err(2'b10);
        t_cfg_err(2'b11);
        t_stream(2'b11, 1'b1, 3, "R5 DDR 14:1 after error");
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule